// File: doc/BRIEF.md
# Infrared Transmit Carrier Modulator

This block turns a short queue of run-length samples into the drive signals for infrared emitters. Software writes samples into two one-byte slots. Each sample is either a pulse (bit 7 set) or a space (bit 7 clear), and bits 6:0 give its length in sample periods. While a pulse plays, the emitters carry a square carrier built from a 500 ns time unit. The carrier's period and high time are set by two registers, and a polarity bit can flip it. Software can also switch the carrier off, so that pulses become a steady active level. A global invert bit flips every emitter level, idle level included.

The slots are consumed in strict alternation. When one sample ends and the next slot already holds data, that sample starts on the very next clock, with no gap. When the next slot is empty at the end of a sample, transmission stops. If enabled, an interrupt then tells software that the queued samples are used up. The interrupt stays raised until software acknowledges it. Each emitter output has its own enable. An emitter that is disabled or idle rests at the inactive level.

The clock-to-unit ratio and the sample period length are parameters. The defaults are 50 clocks per 500 ns unit (100 MHz) and 100 units per sample period (50 µs).

Top module: `ir_tx_modulator`

## Requirements
- R1: Bus writes at address 0 set control (bit 0 transmit enable, bit 1 interrupt enable, bit 2 output invert, bit 3 carrier on, bits 7:4 emitter enables). Writes at address 1 set the carrier period (bit 7 carrier polarity, bits 6:0 period). Writes at address 2 set the carrier high time (bits 6:0). Addresses 3 and 4 load slot 0 and slot 1. Address 5 is status. Reads at addresses 0, 1 and 2 return the stored values, with bit 7 of address 2 reading 0.
- R2: A sample with duration field d lasts max(d,1) × SAMPLE_UNITS × UNIT_CYCLES clocks. Consecutive samples follow each other with no idle clock between them. During a space the emitter is at the inactive level.
- R3: During a pulse with the carrier on, the unit index u is counted from the start of the sample. The raw carrier is high while (u mod P) < H, where P is the period field clamped to a minimum of 2 and H is the high time. A high time of P or more therefore gives a constant-high carrier.
- R4: Period register bit 7 set inverts the carrier.
- R5: With the carrier-on bit clear, a pulse drives a steady active level.
- R6: The invert bit flips every emitter level, including spaces and idle.
- R7: An emitter whose enable bit is clear stays at the inactive level (the invert bit's value).
- R8: Samples are taken from slot 0 first after reset or disable, and then alternately from slot 1, slot 0, and so on. A written slot that is not next in turn is held and does not start transmission. The first sample appears on the emitters two clock edges after the edge that makes transmission possible, whether that edge writes the slot or sets the enable.
- R9: Clearing transmit enable during a transmission stops it. From the second edge after that write the emitters are inactive. Both slots are discarded, the slot pointer returns to slot 0, and no interrupt is raised.
- R10: When a transmission ends because the next slot is empty and interrupt enable is set, irq_o rises one edge after the last cycle of the final sample. It stays high until software writes 1 to bit 0 of address 5. With interrupt enable clear, irq_o stays low. Status reads: bit 0 interrupt pending, bit 1 busy, bit 2 slot 0 full, bit 3 slot 1 full.
- R11: After reset all registers read 0, the emitters are 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| emit_o | output | NUM_EMIT | Emitter drive levels, registered |
| irq_o | output | 1 | Transmission-done interrupt |

## Verification
A wrong slot pointer or a stale slot-full flag shows up as the wrong sample order. Depending on the fault, that is either a pulse where a space was expected or a transmission that never starts. The first is visible within one sample length. The second shows in the status read that follows. A duration counter off by one moves every later edge by a full sample period, and a carrier counter that wraps at the wrong point shifts carrier edges within the first carrier period of a pulse. Both are caught by comparing every emitter clock against an independently computed waveform. A fault in the interrupt path shows as irq_o rising one or more edges away from the end of the burst, or not being held until it is acknowledged.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int NSLOT = 2;
  localparam int DUR_W = 7;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_CPER  = 3'd1;
  localparam logic [2:0] ADDR_CHIGH = 3'd2;
  localparam logic [2:0] ADDR_SLOT0 = 3'd3;
  localparam logic [2:0] ADDR_SLOT1 = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;

  typedef struct packed {
    logic             pulse;
    logic [DUR_W-1:0] dur;
  } sample_t;

  typedef struct packed {
    logic [3:0] emit_en;
    logic       carrier_on;
    logic       out_inv;
    logic       irq_en;
    logic       tx_en;
  } ctrl_t;

  // carrier period in units, never below two
  function automatic logic [6:0] eff_period(input logic [6:0] p);
    return (p < 7'd2) ? 7'd2 : p;
  endfunction

  // sample length in sample periods, zero counts as one
  function automatic logic [DUR_W-1:0] eff_dur(input logic [DUR_W-1:0] d);
    return (d == '0) ? DUR_W'(1) : d;
  endfunction

  function automatic logic carrier_level(input logic [6:0] cnt,
                                         input logic [6:0] high,
                                         input logic       pol);
    return (cnt < high) ^ pol;
  endfunction

  function automatic logic drive_level(input logic in_pulse,
                                       input logic car_on,
                                       input logic car,
                                       input logic inv);
    logic raw;
    raw = in_pulse ? (car_on ? car : 1'b1) : 1'b0;
    return raw ^ inv;
  endfunction

endpackage

// File: rtl/ir_tx_regs.sv
module ir_tx_regs
  import ir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic [7:0]       status_i,
  output logic [7:0]       bus_rdata,
  output ctrl_t            ctrl_o,
  output logic [7:0]       cper_o,
  output logic [6:0]       chigh_o,
  output logic [NSLOT-1:0] slot_wr_o,
  output sample_t          slot_data_o,
  output logic             irq_ack_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      cper_o  <= '0;
      chigh_o <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_CTRL:  ctrl_o  <= ctrl_t'(bus_wdata);
        ADDR_CPER:  cper_o  <= bus_wdata;
        ADDR_CHIGH: chigh_o <= bus_wdata[6:0];
        default: ;
      endcase
    end
  end

  assign slot_wr_o[0] = bus_wr && (bus_addr == ADDR_SLOT0);
  assign slot_wr_o[1] = bus_wr && (bus_addr == ADDR_SLOT1);
  assign slot_data_o  = sample_t'(bus_wdata);
  assign irq_ack_o    = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = ctrl_o;
      ADDR_CPER:  bus_rdata = cper_o;
      ADDR_CHIGH: bus_rdata = {1'b0, chigh_o};
      ADDR_STAT:  bus_rdata = status_i;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ir_tx_timebase.sv
module ir_tx_timebase #(
  parameter int UNIT_CYCLES  = 50,
  parameter int SAMPLE_UNITS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic unit_tick,
  output logic sample_tick
);

  localparam int PRE_W = (UNIT_CYCLES  > 1) ? $clog2(UNIT_CYCLES)  : 1;
  localparam int SMP_W = (SAMPLE_UNITS > 1) ? $clog2(SAMPLE_UNITS) : 1;

  generate
    if (UNIT_CYCLES == 1) begin : g_pre_none
      assign unit_tick = run;
    end else begin : g_pre_cnt
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pre_q <= '0;
        else if (!run)            pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
      end
      assign unit_tick = run && (pre_q == PRE_LAST);
    end

    if (SAMPLE_UNITS == 1) begin : g_smp_none
      assign sample_tick = unit_tick;
    end else begin : g_smp_cnt
      localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_UNITS - 1);
      logic [SMP_W-1:0] smp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          smp_q <= '0;
        else if (!run)       smp_q <= '0;
        else if (unit_tick) begin
          if (smp_q == SMP_LAST) smp_q <= '0;
          else                   smp_q <= smp_q + 1'b1;
        end
      end
      assign sample_tick = unit_tick && (smp_q == SMP_LAST);
    end
  endgenerate

endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
  import ir_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       unit_tick,
  input  logic [7:0] cper,
  input  logic [6:0] chigh,
  output logic       carrier
);

  logic [6:0] cnt_q;
  logic [6:0] per_eff;
  logic       wrap;

  assign per_eff = eff_period(cper[6:0]);
  assign wrap    = (cnt_q >= per_eff - 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart)   cnt_q <= '0;
    else if (unit_tick) cnt_q <= wrap ? 7'd0 : cnt_q + 7'd1;
  end

  assign carrier = carrier_level(cnt_q, chigh, cper[7]);

endmodule

// File: rtl/ir_tx_sequencer.sv
module ir_tx_sequencer
  import ir_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [NSLOT-1:0] slot_wr,
  input  sample_t          slot_wdata,
  input  logic             sample_tick,
  output logic             busy,
  output logic             cur_pulse,
  output logic             sample_load,
  output logic             run_done,
  output logic [NSLOT-1:0] slot_valid
);

  sample_t          slot_q [NSLOT];
  sample_t          cur_q;
  logic [DUR_W-1:0] dur_left;
  logic             rd_ptr;
  logic             head_valid;
  logic             end_now;
  logic             abort;

  assign head_valid  = slot_valid[rd_ptr];
  assign end_now     = busy && sample_tick && (dur_left == DUR_W'(1));
  assign sample_load = tx_en && head_valid && (!busy || end_now);
  assign run_done    = tx_en && end_now && !head_valid;
  assign abort       = busy && !tx_en;
  assign cur_pulse   = cur_q.pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rd_ptr     <= 1'b0;
      dur_left   <= '0;
      cur_q      <= '0;
      slot_valid <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else begin
      if (!tx_en) begin
        busy   <= 1'b0;
        rd_ptr <= 1'b0;
        if (abort) slot_valid <= '0;
      end else if (sample_load) begin
        cur_q              <= slot_q[rd_ptr];
        dur_left           <= eff_dur(slot_q[rd_ptr].dur);
        busy               <= 1'b1;
        slot_valid[rd_ptr] <= 1'b0;
        rd_ptr             <= ~rd_ptr;
      end else if (end_now) begin
        busy <= 1'b0;
      end else if (busy && sample_tick) begin
        dur_left <= dur_left - DUR_W'(1);
      end
      // a fresh write wins over a same-cycle consume or flush
      for (int i = 0; i < NSLOT; i++) begin
        if (slot_wr[i]) begin
          slot_q[i]     <= slot_wdata;
          slot_valid[i] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator
  import ir_tx_pkg::*;
#(
  parameter int UNIT_CYCLES  = 50,
  parameter int SAMPLE_UNITS = 100,
  parameter int NUM_EMIT     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [NUM_EMIT-1:0] emit_o,
  output logic                irq_o
);

  ctrl_t               ctrl;
  logic [7:0]          cper;
  logic [6:0]          chigh;
  logic [NSLOT-1:0]    slot_wr;
  sample_t             slot_data;
  logic                irq_ack;
  logic [7:0]          status;

  logic                tx_en_w, irq_en_w, inv_w, caron_w;
  logic [NUM_EMIT-1:0] emit_en_w;

  logic                busy_w, cur_pulse_w, sample_load_w, run_done_w;
  logic [NSLOT-1:0]    slot_valid_w;
  logic                unit_tick_w, sample_tick_w, carrier_w;
  logic                drive_w;
  logic                irq_q;

  assign tx_en_w   = ctrl.tx_en;
  assign irq_en_w  = ctrl.irq_en;
  assign inv_w     = ctrl.out_inv;
  assign caron_w   = ctrl.carrier_on;
  assign emit_en_w = ctrl.emit_en[NUM_EMIT-1:0];

  assign status = {4'b0000, slot_valid_w[1], slot_valid_w[0], busy_w, irq_q};

  ir_tx_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .status_i    (status),
    .bus_rdata   (bus_rdata),
    .ctrl_o      (ctrl),
    .cper_o      (cper),
    .chigh_o     (chigh),
    .slot_wr_o   (slot_wr),
    .slot_data_o (slot_data),
    .irq_ack_o   (irq_ack)
  );

  ir_tx_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en_w),
    .slot_wr     (slot_wr),
    .slot_wdata  (slot_data),
    .sample_tick (sample_tick_w),
    .busy        (busy_w),
    .cur_pulse   (cur_pulse_w),
    .sample_load (sample_load_w),
    .run_done    (run_done_w),
    .slot_valid  (slot_valid_w)
  );

  ir_tx_timebase #(
    .UNIT_CYCLES  (UNIT_CYCLES),
    .SAMPLE_UNITS (SAMPLE_UNITS)
  ) u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (busy_w),
    .unit_tick   (unit_tick_w),
    .sample_tick (sample_tick_w)
  );

  ir_tx_carrier u_car (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (sample_load_w),
    .unit_tick (unit_tick_w),
    .cper      (cper),
    .chigh     (chigh),
    .carrier   (carrier_w)
  );

  assign drive_w = drive_level(busy_w && cur_pulse_w, caron_w, carrier_w, inv_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq_q <= 1'b0;
    else if (run_done_w && irq_en_w) irq_q <= 1'b1;
    else if (irq_ack)                irq_q <= 1'b0;
  end
  assign irq_o = irq_q;

  generate
    for (genvar e = 0; e < NUM_EMIT; e++) begin : g_emit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= emit_en_w[e] ? drive_w : inv_w;
      end
      assign emit_o[e] = q;
    end
  endgenerate

endmodule

// File: rtl/ir_tx_modulator_chk.sv
module ir_tx_modulator_chk #(
  parameter int NUM_EMIT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                tx_en,
  input logic                irq_en,
  input logic                out_inv,
  input logic                carrier_on,
  input logic                cur_pulse,
  input logic                run_done,
  input logic                irq,
  input logic [NUM_EMIT-1:0] emit,
  input logic [NUM_EMIT-1:0] emit_en
);

  assert_txoff_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy);

  assert_done_goes_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> !busy);

  assert_done_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && irq_en) |=> irq);

  assert_irq_only_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(run_done) && $past(irq_en)));

  generate
    for (genvar e = 0; e < NUM_EMIT; e++) begin : g_chk
      assert_idle_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (emit[e] == $past(out_inv)));

      assert_space_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cur_pulse) |=> (emit[e] == $past(out_inv)));

      assert_steady_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_pulse && !carrier_on && emit_en[e]) |=> (emit[e] == !$past(out_inv)));

      assert_disabled_emitter_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_en[e] |=> (emit[e] == $past(out_inv)));
    end
  endgenerate

endmodule

bind ir_tx_modulator ir_tx_modulator_chk #(.NUM_EMIT(NUM_EMIT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .tx_en      (tx_en_w),
  .irq_en     (irq_en_w),
  .out_inv    (inv_w),
  .carrier_on (caron_w),
  .cur_pulse  (cur_pulse_w),
  .run_done   (run_done_w),
  .irq        (irq_o),
  .emit       (emit_o),
  .emit_en    (emit_en_w)
);

// File: tb/ir_tx_modulator_tb_top.sv
module ir_tx_modulator_tb_top;

  localparam int UC = 2;
  localparam int SU = 3;
  localparam int NE = 2;

  localparam logic [2:0] A_CTRL = 3'd0, A_CPER = 3'd1, A_CHIGH = 3'd2;
  localparam logic [2:0] A_S0 = 3'd3, A_S1 = 3'd4, A_STAT = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NE-1:0] emit;
  logic          irq;

  always #4 clk = ~clk;

  ir_tx_modulator #(.UNIT_CYCLES(UC), .SAMPLE_UNITS(SU), .NUM_EMIT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .emit_o(emit), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] c_per, c_high;
  logic       c_caron, c_inv, c_irqen;
  logic [1:0] c_en;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctrl_byte(input logic tx);
    return {2'b00, c_en, c_caron, c_inv, c_irqen, tx};
  endfunction

  function automatic int dur_cycles(input logic [7:0] s);
    int d;
    d = int'(s[6:0]);
    if (d == 0) d = 1;
    return d * SU * UC;
  endfunction

  // expected drive level n cycles into the run (before emitter enables)
  function automatic logic lvl_at(input int n, input logic [7:0] sa,
                                  input logic [7:0] sb, input int ns);
    int la, lb, m, p, u, c;
    logic [7:0] s;
    logic car;
    if (n < 0) return c_inv;
    la = dur_cycles(sa);
    lb = (ns > 1) ? dur_cycles(sb) : 0;
    if (n < la) begin s = sa; m = n; end
    else if (n < la + lb) begin s = sb; m = n - la; end
    else return c_inv;
    if (!s[7]) return c_inv;
    if (!c_caron) return !c_inv;
    p = int'(c_per[6:0]);
    if (p < 2) p = 2;
    u = m / UC;
    c = u % p;
    car = (c < int'(c_high[6:0])) ^ c_per[7];
    return car ^ c_inv;
  endfunction

  task automatic check_run(input logic [7:0] sa, input logic [7:0] sb,
                           input int ns, input string tag);
    int lt;
    bit bad_e, bad_i;
    logic exp_e, exp_i;
    lt = dur_cycles(sa) + ((ns > 1) ? dur_cycles(sb) : 0);
    bad_e = 0; bad_i = 0;
    for (int k = 1; k <= lt + 4; k++) begin
      @(negedge clk);
      for (int e = 0; e < NE; e++) begin
        exp_e = c_en[e] ? lvl_at(k - 2, sa, sb, ns) : c_inv;
        if (emit[e] !== exp_e && !bad_e) begin
          $display("FAIL %s emitter%0d cycle %0d actual=%b expected=%b", tag, e, k, emit[e], exp_e);
          bad_e = 1;
        end
      end
      exp_i = c_irqen && (k >= lt + 1);
      if (irq !== exp_i && !bad_i) begin
        $display("FAIL %s irq cycle %0d actual=%b expected=%b", tag, k, irq, exp_i);
        bad_i = 1;
      end
    end
    checks += 2;
    errors += int'(bad_e) + int'(bad_i);
  endtask

  task automatic run_burst(input logic [7:0] per, input logic [7:0] high, input logic [1:0] en,
                           input logic caron, input logic inv, input logic irqen,
                           input logic [7:0] sa, input logic [7:0] sb, input string tag);
    logic [7:0] st;
    c_per = per; c_high = high; c_en = en; c_caron = caron; c_inv = inv; c_irqen = irqen;
    bus_write(A_CPER, per);
    bus_write(A_CHIGH, high);
    bus_write(A_S0, sa);
    bus_write(A_S1, sb);
    bus_write(A_CTRL, ctrl_byte(1'b1));
    check_run(sa, sb, 2, tag);
    bus_read(A_STAT, st);
    check("R10", "status after burst", int'(st), int'({7'b0, irqen}));
    if (irqen) begin
      repeat (5) @(negedge clk);
      check("R10", "irq held", int'(irq), 1);
      bus_write(A_STAT, 8'h01);
      check("R10", "irq after ack", int'(irq), 0);
    end
    bus_write(A_CTRL, 8'h00);
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] rp, rh;
    bit bad;
    void'($urandom(32'd7301));
    c_per = '0; c_high = '0; c_en = '0; c_caron = 0; c_inv = 0; c_irqen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11", "emit after reset", int'(emit), 0);
    check("R11", "irq after reset", int'(irq), 0);
    bus_read(A_CTRL, rd);  check("R11", "ctrl after reset", int'(rd), 0);
    bus_read(A_CPER, rd);  check("R11", "period after reset", int'(rd), 0);
    bus_read(A_STAT, rd);  check("R11", "status after reset", int'(rd), 0);

    // R1 readback
    bus_write(A_CPER, 8'h85);  bus_read(A_CPER, rd);  check("R1", "period readback", int'(rd), 8'h85);
    bus_write(A_CHIGH, 8'hFF); bus_read(A_CHIGH, rd); check("R1", "high readback", int'(rd), 8'h7F);
    bus_write(A_CTRL, 8'h3C);  bus_read(A_CTRL, rd);  check("R1", "ctrl readback", int'(rd), 8'h3C);
    bus_write(A_CTRL, 8'h00);

    // directed corners
    run_burst(8'd6, 8'd3, 2'b11, 1, 0, 1, 8'h82, 8'h03, "R3");
    run_burst(8'd4, 8'd4, 2'b11, 1, 0, 0, 8'h81, 8'h81, "R3");
    run_burst(8'd0, 8'd1, 2'b01, 1, 0, 0, 8'h82, 8'h01, "R3");
    run_burst(8'h85, 8'd2, 2'b11, 1, 0, 1, 8'h83, 8'h02, "R4");
    run_burst(8'd5, 8'd2, 2'b11, 0, 0, 1, 8'h84, 8'h02, "R5");
    run_burst(8'd5, 8'd2, 2'b11, 1, 1, 1, 8'h02, 8'h83, "R6");
    run_burst(8'd7, 8'd3, 2'b10, 1, 0, 0, 8'h83, 8'h81, "R7");
    run_burst(8'd3, 8'd1, 2'b11, 0, 1, 0, 8'h80, 8'h00, "R2");
    run_burst(8'd9, 8'd4, 2'b11, 1, 0, 0, 8'h81, 8'h01, "R10");

    // constrained random bursts
    for (int i = 0; i < 24; i++) begin
      rp = 8'($urandom % 256);
      rh = 8'($urandom % (int'(rp[6:0]) + 3));
      run_burst(rp, rh, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                1'($urandom % 2), 8'($urandom % 256), 8'($urandom % 256), "R2");
    end

    // R8 alternation and held slot
    c_per = 8'd4; c_high = 8'd2; c_en = 2'b11; c_caron = 0; c_inv = 0; c_irqen = 0;
    bus_write(A_CTRL, ctrl_byte(1'b1));
    bus_write(A_S0, 8'h82);
    check_run(8'h82, 8'h00, 1, "R8");
    bus_write(A_S0, 8'h83);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (emit !== 2'b00) bad = 1;
    end
    check("R8", "held slot does not start", int'(bad), 0);
    bus_read(A_STAT, rd); check("R8", "status with held slot", int'(rd), 8'h04);
    bus_write(A_S1, 8'h02);
    check_run(8'h02, 8'h83, 2, "R8");
    bus_write(A_CTRL, 8'h00);

    // R9 abort
    c_per = 8'd10; c_high = 8'd5; c_en = 2'b11; c_caron = 1; c_inv = 1; c_irqen = 1;
    bus_write(A_CPER, c_per);
    bus_write(A_CHIGH, c_high);
    bus_write(A_S0, 8'hE4);
    bus_write(A_S1, 8'h64);
    bus_write(A_CTRL, ctrl_byte(1'b1));
    repeat (20) @(negedge clk);
    bus_write(A_CTRL, ctrl_byte(1'b0));
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (emit !== 2'b11 || irq !== 1'b0) bad = 1;
    end
    check("R9", "inactive after abort", int'(bad), 0);
    bus_read(A_STAT, rd); check("R9", "slots flushed", int'(rd), 0);
    bus_write(A_CTRL, ctrl_byte(1'b1));
    bad = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (emit !== 2'b11) bad = 1;
    end
    check("R9", "no restart after re-enable", int'(bad), 0);
    bus_read(A_STAT, rd); check("R9", "still idle", int'(rd), 0);
    bus_write(A_CTRL, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule